// File: doc/BRIEF.md
# Windowed Carry-Less 32x32 Multiplier

This block forms the 64-bit carry-less product of two 32-bit operands, meaning the product of two polynomials over GF(2), where partial products are combined with XOR and no carries propagate. A request is made by pulsing `start` with the two operands on `a_in` and `b_in`. Some cycles later the block pulses `done` for one cycle and presents the product on two 32-bit words, `prod_lo` for bits 31:0 and `prod_hi` for bits 63:32.

When a request is accepted, the block builds an eight-entry lookup of XOR combinations of the multiplicand. For this lookup, the two most significant bits of the multiplicand are cleared. The multiplier is then read three bits per clock, starting from its least significant end. Each group of three bits selects a lookup entry, which is shifted into position and XORed into a 64-bit accumulator. Eleven such groups cover the multiplier. The last group holds only bits 31:30, with a zero above them. A final cycle adds back the effect of the two multiplicand bits that were left out of the lookup. The block runs one operation at a time. Modular reduction by a field polynomial is left to the user.

Top module: `polymul_gf2_win`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done` is 0 and `prod_lo` and `prod_hi` are 0.
- R2: The value `{prod_hi, prod_lo}` equals the XOR, over every set bit i of the multiplier, of the multiplicand shifted left by i. `prod_lo` carries product bits 31:0 and `prod_hi` carries bits 63:32.
- R3: The product is correct when multiplicand bit 30, bit 31 or both are set, including multiplicands where only those bits are set.
- R4: If `start` is sampled high at a clock edge while the block is idle, `done` is high after exactly the twelfth edge that follows, and at no other time.
- R5: `done` is high for exactly one cycle per accepted request.
- R6: A `start` sampled at any edge between the accepting edge and the completing edge, both included, has no effect on the current result or on its timing.
- R7: A `start` that is high in the same cycle as `done` is accepted as a new request.
- R8: `prod_lo` and `prod_hi` change only in the cycle where `done` is high. They keep their value until the next completion.
- R9: A zero multiplicand gives a zero product, and a multiplier of 1 gives the multiplicand as the product.
- R10: Operands are captured at the accepting edge. Changes on `a_in` and `b_in` after that edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only while idle |
| a_in | input | 32 | Multiplicand, sampled with an accepted `start` |
| b_in | input | 32 | Multiplier, sampled with an accepted `start` |
| done | output | 1 | One-cycle completion pulse |
| prod_lo | output | 32 | Product bits 31:0 |
| prod_hi | output | 32 | Product bits 63:32 |

## Verification
Two things can fall on the same clock edge: a new `start`, and either the completing correction step or the cycle in which `done` is high. The bench provokes both by holding `start` high for many cycles while the operands change on every clock. This puts a request on the completing edge, where it must be dropped, and in the `done` cycle, where it must be taken. A cycle-by-cycle behavioural model applies the same acceptance rule and predicts `done` and the product on every clock. Any request that is wrongly taken or wrongly dropped therefore shows up as a mismatch in timing or in product value.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

  typedef enum logic [1:0] {
    GFM_IDLE = 2'd0,
    GFM_SCAN = 2'd1,
    GFM_FIX  = 2'd2
  } gfm_phase_e;

  // number of window steps needed to cover an operand
  function automatic int gfm_windows(input int op_w, input int win_w);
    return (op_w + win_w - 1) / win_w;
  endfunction

endpackage

// File: rtl/gfm_ctrl.sv
module gfm_ctrl #(
  parameter int NWIN  = 11,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             load,
  output logic             scan_en,
  output logic             fix_en,
  output logic [IDX_W-1:0] win_idx
);
  import gfm_pkg::*;

  gfm_phase_e phase_q;

  assign load    = (phase_q == GFM_IDLE) && start;
  assign scan_en = (phase_q == GFM_SCAN);
  assign fix_en  = (phase_q == GFM_FIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= GFM_IDLE;
      win_idx <= '0;
    end else begin
      unique case (phase_q)
        GFM_IDLE: begin
          if (start) begin
            phase_q <= GFM_SCAN;
            win_idx <= '0;
          end
        end
        GFM_SCAN: begin
          if (win_idx == IDX_W'(NWIN - 1)) phase_q <= GFM_FIX;
          else                             win_idx <= win_idx + 1'b1;
        end
        GFM_FIX: phase_q <= GFM_IDLE;
        default: phase_q <= GFM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gfm_table.sv
module gfm_table #(
  parameter int OP_W  = 32,
  parameter int WIN_W = 3
) (
  input  logic                clk,
  input  logic                load,
  input  logic [OP_W-WIN_W:0] a_lo,
  input  logic [WIN_W-1:0]    rd_idx,
  output logic [OP_W-1:0]     rd_data
);
  localparam int TAB_N = 1 << WIN_W;

  logic [OP_W-1:0] tab_q [TAB_N];
  logic [OP_W-1:0] tab_d [TAB_N];

  // entry i = XOR of (a_lo << j) for each set bit j of i
  always_comb begin
    for (int i = 0; i < TAB_N; i++) begin
      tab_d[i] = '0;
      for (int j = 0; j < WIN_W; j++) begin
        if (i[j]) tab_d[i] = tab_d[i] ^ (OP_W'(a_lo) << j);
      end
    end
  end

  // written only on request acceptance, read asynchronously
  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < TAB_N; i++) tab_q[i] <= tab_d[i];
    end
  end

  assign rd_data = tab_q[rd_idx];

endmodule

// File: rtl/gfm_window_step.sv
module gfm_window_step #(
  parameter int OP_W  = 32,
  parameter int WIN_W = 3,
  parameter int NWIN  = 11,
  parameter int IDX_W = 4
) (
  input  logic [OP_W-1:0]   b,
  input  logic [IDX_W-1:0]  win_idx,
  output logic [WIN_W-1:0]  win_bits,
  input  logic [OP_W-1:0]   entry,
  input  logic [2*OP_W-1:0] acc_in,
  output logic [2*OP_W-1:0] acc_out
);
  localparam int BEXT_W = NWIN * WIN_W;
  localparam int SH_W   = $clog2(BEXT_W);

  logic [BEXT_W-1:0] b_ext;
  logic [SH_W-1:0]   sh;

  assign b_ext    = BEXT_W'(b);
  assign sh       = SH_W'(win_idx) * SH_W'(WIN_W);
  assign win_bits = b_ext[sh +: WIN_W];
  assign acc_out  = acc_in ^ ((2*OP_W)'(entry) << sh);

endmodule

// File: rtl/gfm_fix.sv
module gfm_fix #(
  parameter int OP_W  = 32,
  parameter int WIN_W = 3
) (
  input  logic [2*OP_W-1:0] acc_in,
  input  logic [WIN_W-2:0]  a_top,
  input  logic [OP_W-1:0]   b,
  output logic [2*OP_W-1:0] acc_out
);
  // a_top[k] stands for multiplicand bit OP_W-WIN_W+1+k
  always_comb begin
    acc_out = acc_in;
    for (int k = 0; k < WIN_W - 1; k++) begin
      if (a_top[k]) acc_out = acc_out ^ ((2*OP_W)'(b) << (OP_W - WIN_W + 1 + k));
    end
  end

endmodule

// File: rtl/polymul_gf2_win.sv
module polymul_gf2_win #(
  parameter int OP_W  = 32,
  parameter int WIN_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OP_W-1:0] a_in,
  input  logic [OP_W-1:0] b_in,
  output logic            done,
  output logic [OP_W-1:0] prod_lo,
  output logic [OP_W-1:0] prod_hi
);
  localparam int NWIN  = gfm_pkg::gfm_windows(OP_W, WIN_W);
  localparam int IDX_W = $clog2(NWIN + 1);

  logic               load, scan_en, fix_en;
  logic [IDX_W-1:0]   win_idx;
  logic [WIN_W-1:0]   win_bits;
  logic [OP_W-1:0]    entry;
  logic [WIN_W-2:0]   a_top_q;
  logic [OP_W-1:0]    b_q;
  logic [2*OP_W-1:0]  acc_q, acc_step, acc_fix, prod_q;

  gfm_ctrl #(.NWIN(NWIN), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .scan_en(scan_en), .fix_en(fix_en), .win_idx(win_idx)
  );

  gfm_table #(.OP_W(OP_W), .WIN_W(WIN_W)) u_table (
    .clk(clk), .load(load), .a_lo(a_in[OP_W-WIN_W:0]),
    .rd_idx(win_bits), .rd_data(entry)
  );

  gfm_window_step #(.OP_W(OP_W), .WIN_W(WIN_W), .NWIN(NWIN), .IDX_W(IDX_W)) u_step (
    .b(b_q), .win_idx(win_idx), .win_bits(win_bits),
    .entry(entry), .acc_in(acc_q), .acc_out(acc_step)
  );

  gfm_fix #(.OP_W(OP_W), .WIN_W(WIN_W)) u_fix (
    .acc_in(acc_q), .a_top(a_top_q), .b(b_q), .acc_out(acc_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_top_q <= '0;
      b_q     <= '0;
      acc_q   <= '0;
      prod_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        a_top_q <= a_in[OP_W-1 -: WIN_W-1];
        b_q     <= b_in;
        acc_q   <= '0;
      end
      if (scan_en) acc_q <= acc_step;
      if (fix_en) begin
        prod_q <= acc_fix;
        done   <= 1'b1;
      end
    end
  end

  assign prod_lo = prod_q[OP_W-1:0];
  assign prod_hi = prod_q[2*OP_W-1:OP_W];

endmodule

// File: rtl/gfm_mul_chk.sv
module gfm_mul_chk #(
  parameter int OP_W  = 32,
  parameter int WIN_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [OP_W-1:0] a_in,
  input logic [OP_W-1:0] b_in,
  input logic            done,
  input logic [OP_W-1:0] prod_lo,
  input logic [OP_W-1:0] prod_hi
);
  localparam int LAT  = gfm_pkg::gfm_windows(OP_W, WIN_W) + 1;
  localparam int CW   = $clog2(LAT + 1) + 1;

  logic            busy_c;
  logic [CW-1:0]   cnt;
  logic [OP_W-1:0] a_lat, b_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_c <= 1'b0;
      cnt    <= '0;
      a_lat  <= '0;
      b_lat  <= '0;
    end else if (busy_c) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(LAT - 1)) busy_c <= 1'b0;
    end else if (start) begin
      busy_c <= 1'b1;
      cnt    <= '0;
      a_lat  <= a_in;
      b_lat  <= b_in;
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy_c && cnt == CW'(LAT))); // R4
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_c |-> !done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(prod_lo) && $stable(prod_hi))); // R8
  AST_ZERO_MULTIPLICAND: assert property (@(posedge clk) disable iff (rst)
    (done && a_lat == '0) |-> (prod_lo == '0 && prod_hi == '0)); // R9
  AST_UNIT_MULTIPLIER: assert property (@(posedge clk) disable iff (rst)
    (done && b_lat == OP_W'(1)) |-> (prod_lo == a_lat && prod_hi == '0)); // R9

endmodule

bind polymul_gf2_win gfm_mul_chk #(.OP_W(OP_W), .WIN_W(WIN_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
  .done(done), .prod_lo(prod_lo), .prod_hi(prod_hi)
);

// File: tb/polymul_gf2_win_bench.sv
module polymul_gf2_win_bench;
  localparam int CLK_NS = 20;
  localparam int LAT    = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] a_in = '0, b_in = '0;
  logic        done;
  logic [31:0] prod_lo, prod_hi;

  int    n_checks = 0, n_fails = 0;
  bit    chk_on = 1'b0;
  string tag = "R2";

  // reference model state
  bit          m_busy = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_a = '0, m_b = '0;
  bit          exp_done = 1'b0;
  logic [63:0] exp_prod = '0;

  always #(CLK_NS/2) clk = ~clk;

  polymul_gf2_win u_polymul_gf2_win (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .done(done), .prod_lo(prod_lo), .prod_hi(prod_hi)
  );

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 32; i++) if (b[i]) r = r ^ ({32'b0, a} << i);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cnt = 0; exp_done = 0; exp_prod = '0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      exp_done = 0;
      if (was_busy) begin
        m_cnt++;
        if (m_cnt == LAT) begin
          exp_done = 1;
          exp_prod = ref_mul(m_a, m_b);
          m_busy   = 0;
        end
      end
      if (start && !was_busy) begin
        m_busy = 1; m_cnt = 0; m_a = a_in; m_b = b_in;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check({tag, " R4 R5 R6 R7 done"}, 64'(done), 64'(exp_done));
      check({tag, " R8 product"}, {prod_hi, prod_lo}, exp_prod);
    end
  end

  task automatic run_op(input logic [31:0] a, input logic [31:0] b);
    @(posedge clk); #2;
    start = 1'b1; a_in = a; b_in = b;
    @(posedge clk); #2;
    start = 1'b0; a_in = $urandom; b_in = $urandom; // R10 scramble
    repeat (LAT + 2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset done", 64'(done), 64'd0);
    check("R1 reset product", {prod_hi, prod_lo}, 64'd0);
    @(posedge clk); #2;
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {31'b0, done, prod_hi, prod_lo}, 64'd0);
    chk_on = 1'b1;

    tag = "R9";
    run_op(32'h0, 32'hFFFF_FFFF);
    run_op(32'hDEAD_BEEF, 32'h1);
    run_op(32'h1234_5678, 32'h0);
    tag = "R3";
    run_op(32'hC000_0000, 32'hFFFF_FFFF);
    run_op(32'h4000_0000, 32'h8000_0001);
    run_op(32'h8000_0000, 32'hC000_0000);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    tag = "R2 R10";
    run_op(32'hFFFF_FFFF, 32'h0000_0007);
    for (int i = 0; i < 20; i++) run_op($urandom, $urandom);

    // start held high: hits the completing edge and the done cycle
    tag = "R6 R7";
    @(posedge clk); #2;
    start = 1'b1;
    for (int i = 0; i < 60; i++) begin
      a_in = $urandom; b_in = $urandom;
      @(posedge clk); #2;
    end
    start = 1'b0;
    repeat (LAT + 3) @(posedge clk);
    @(negedge clk);
    chk_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog R4: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule